// File: doc/BRIEF.md
# Page Access Rights Checker

This combinational block decides what a single memory access may do once the translation lookaside buffer has produced a matching entry. It takes the entry's access fields, the current privilege level and the kind of access being made. These fields are the page type code, two privilege bounds, an access identifier, and the dirty, break and trap flags. It returns the permission bits the entry grants and, when the access must not proceed, a fault code.

The decision is made in a fixed order. First the privilege bounds and the page type give a base permission. Next an optional protection-identifier match removes write permission. An unchecked probe stops at this point and gets the permission without any fault. Then the requested kind is checked against the permission. Last, the dirty, break and trap conditions are resolved, and each of them can narrow the permission it returns. Address arithmetic and exception delivery belong to other blocks.

Top module: `page_rights_check`

## Requirements
- R1: Permission bit 0 (read) requires priv_lvl <= ent_rd_pl. Bit 1 (write) requires priv_lvl <= ent_wr_pl. Bit 2 (execute) requires ent_wr_pl <= priv_lvl <= ent_rd_pl.
- R2: The type code selects from the privilege-qualified bits as follows: 0 gives read; 1 gives read and write; 2 gives read and execute; 3 gives all three; 4 to 7 give execute alone.
- R3: When pid_chk_en is 1 and ent_id is non-zero, the value {ent_id, 1'b1} is compared with every pid_regs slot (slot k is bits [k*(ID_W+1) +: ID_W+1]). On any equality, write permission is cleared. If acc_kind is write (2), fault 1 is raised, and it takes precedence over every later check.
- R4: When pid_chk_en is 0 or ent_id is zero, the protection-identifier registers have no effect.
- R5: A probe (acc_kind 0) returns the permission with no fault, and the dirty, break and trap flags leave it unchanged.
- R6: For acc_kind read (1), write (2) or execute (3), if the matching permission bit is clear, the block returns the permission unchanged. The fault is 2 for execute and 3 for read or write.
- R7: On an access that passes R6 with ent_dirty 0, write permission is cleared, and a write raises fault 4.
- R8: On an access that passes R6 with ent_brk 1, write permission is cleared, and a write raises fault 5.
- R9: On an access that passes R6 with ent_trap 1, the permission is reduced to execute only, and a read or write raises fault 6.
- R10: When several of the R7 to R9 faults apply, fault 6 wins over fault 5, and fault 5 wins over fault 4.
- R11: fault_vld is 1 exactly when fault_code is not 0 (no fault).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_lvl | input | PL_W | Current privilege level, 0 most privileged |
| acc_kind | input | 2 | 0 probe, 1 read, 2 write, 3 execute |
| pid_chk_en | input | 1 | Enables protection-identifier matching |
| pid_regs | input | NUM_PID*(ID_W+1) | Protection-identifier registers, slot 0 in the low bits |
| ent_type | input | 3 | Page type code of the entry |
| ent_rd_pl | input | PL_W | Least privileged level allowed to read |
| ent_wr_pl | input | PL_W | Least privileged level allowed to write |
| ent_id | input | ID_W | Access identifier of the entry, 0 means public |
| ent_dirty | input | 1 | Page already written |
| ent_brk | input | 1 | Break on write |
| ent_trap | input | 1 | Trap on data reference |
| perm | output | 3 | Granted permission: bit 0 read, bit 1 write, bit 2 execute |
| fault_vld | output | 1 | A fault is reported |
| fault_code | output | 4 | Fault code, 0 when no fault |

## Verification
The bench builds the block with PL_W = 2, ID_W = 8 and NUM_PID = 4. With these values every privilege level and every bound can be written directly into a vector. The 9-bit identifier slots make it easy to place a match in the last slot and a near miss that differs only in bit 0. The vector table covers the page-type and privilege combinations and the ordering among the dirty, break and trap faults. Directed cases then cover identifier matching, the disabled and public cases, and identifier-fault precedence over the dirty check.

// File: rtl/page_rights_pkg.sv
package page_rights_pkg;

  typedef enum logic [1:0] {
    ACC_PROBE = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_EXEC  = 2'd3
  } acc_e;

  typedef enum logic [3:0] {
    FLT_NONE        = 4'd0,
    FLT_PROT_ID     = 4'd1,
    FLT_INSN_PROT   = 4'd2,
    FLT_DATA_RIGHTS = 4'd3,
    FLT_DIRTY       = 4'd4,
    FLT_BREAK       = 4'd5,
    FLT_PAGE_REF    = 4'd6
  } fault_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

endpackage

// File: rtl/pr_level_gate.sv
module pr_level_gate #(
  parameter int PL_W = 2
) (
  input  logic [PL_W-1:0] priv_lvl,
  input  logic [PL_W-1:0] rd_pl,
  input  logic [PL_W-1:0] wr_pl,
  output logic [2:0]      lvl_ok
);
  import page_rights_pkg::*;

  always_comb begin
    lvl_ok         = '0;
    lvl_ok[PERM_R] = (priv_lvl <= rd_pl);
    lvl_ok[PERM_W] = (priv_lvl <= wr_pl);
    lvl_ok[PERM_X] = (wr_pl <= priv_lvl) && (priv_lvl <= rd_pl);
  end
endmodule

// File: rtl/pr_type_mask.sv
module pr_type_mask (
  input  logic [2:0] type_code,
  input  logic [2:0] lvl_ok,
  output logic [2:0] base_perm
);
  import page_rights_pkg::*;

  logic [2:0] type_allow;

  always_comb begin
    type_allow = '0;
    if (type_code[2]) begin
      type_allow[PERM_X] = 1'b1;
    end else begin
      type_allow[PERM_R] = 1'b1;
      type_allow[PERM_W] = type_code[0];
      type_allow[PERM_X] = type_code[1];
    end
    base_perm = type_allow & lvl_ok;
  end
endmodule

// File: rtl/pr_pid_match.sv
module pr_pid_match #(
  parameter int ID_W    = 15,
  parameter int NUM_PID = 4
) (
  input  logic                          chk_en,
  input  logic [ID_W-1:0]               ent_id,
  input  logic [NUM_PID*(ID_W+1)-1:0]   pid_regs,
  output logic                          pid_hit
);
  localparam int PID_W = ID_W + 1;

  logic [PID_W-1:0]   key;
  logic [NUM_PID-1:0] slot_eq;

  assign key = {ent_id, 1'b1};

  for (genvar k = 0; k < NUM_PID; k++) begin : g_slot
    assign slot_eq[k] = (pid_regs[k*PID_W +: PID_W] == key);
  end

  assign pid_hit = chk_en && (ent_id != '0) && (|slot_eq);
endmodule

// File: rtl/pr_fault_resolve.sv
module pr_fault_resolve (
  input  logic [1:0] acc_kind,
  input  logic [2:0] base_perm,
  input  logic       pid_hit,
  input  logic       ent_dirty,
  input  logic       ent_brk,
  input  logic       ent_trap,
  output logic [2:0] perm,
  output logic [3:0] fault_code
);
  import page_rights_pkg::*;

  acc_e       kind;
  fault_e     code;
  logic [2:0] req;

  assign kind = acc_e'(acc_kind);

  always_comb begin
    req = '0;
    unique case (kind)
      ACC_READ:  req[PERM_R] = 1'b1;
      ACC_WRITE: req[PERM_W] = 1'b1;
      ACC_EXEC:  req[PERM_X] = 1'b1;
      default:   req = '0;
    endcase
  end

  always_comb begin
    perm = base_perm;
    code = FLT_NONE;
    if (pid_hit) begin
      perm[PERM_W] = 1'b0;
      if (kind == ACC_WRITE) code = FLT_PROT_ID;
    end
    if (code == FLT_NONE && kind != ACC_PROBE) begin
      if ((perm & req) == '0) begin
        code = (kind == ACC_EXEC) ? FLT_INSN_PROT : FLT_DATA_RIGHTS;
      end else begin
        // lowest priority first so later conditions overwrite the code
        if (!ent_dirty) begin
          if (kind == ACC_WRITE) code = FLT_DIRTY;
          perm[PERM_W] = 1'b0;
        end
        if (ent_brk) begin
          if (kind == ACC_WRITE) code = FLT_BREAK;
          perm[PERM_W] = 1'b0;
        end
        if (ent_trap) begin
          if (kind != ACC_EXEC) code = FLT_PAGE_REF;
          perm[PERM_R] = 1'b0;
          perm[PERM_W] = 1'b0;
        end
      end
    end
  end

  assign fault_code = code;
endmodule

// File: rtl/page_rights_check.sv
module page_rights_check #(
  parameter int PL_W    = 2,
  parameter int ID_W    = 15,
  parameter int NUM_PID = 4
) (
  input  logic [PL_W-1:0]                 priv_lvl,
  input  logic [1:0]                      acc_kind,
  input  logic                            pid_chk_en,
  input  logic [NUM_PID*(ID_W+1)-1:0]     pid_regs,
  input  logic [2:0]                      ent_type,
  input  logic [PL_W-1:0]                 ent_rd_pl,
  input  logic [PL_W-1:0]                 ent_wr_pl,
  input  logic [ID_W-1:0]                 ent_id,
  input  logic                            ent_dirty,
  input  logic                            ent_brk,
  input  logic                            ent_trap,
  output logic [2:0]                      perm,
  output logic                            fault_vld,
  output logic [3:0]                      fault_code
);
  logic [2:0] lvl_ok;
  logic [2:0] base_perm;
  logic       pid_hit;

  pr_level_gate #(.PL_W(PL_W)) u_lvl (
    .priv_lvl (priv_lvl),
    .rd_pl    (ent_rd_pl),
    .wr_pl    (ent_wr_pl),
    .lvl_ok   (lvl_ok)
  );

  pr_type_mask u_type (
    .type_code (ent_type),
    .lvl_ok    (lvl_ok),
    .base_perm (base_perm)
  );

  pr_pid_match #(.ID_W(ID_W), .NUM_PID(NUM_PID)) u_pid (
    .chk_en   (pid_chk_en),
    .ent_id   (ent_id),
    .pid_regs (pid_regs),
    .pid_hit  (pid_hit)
  );

  pr_fault_resolve u_res (
    .acc_kind   (acc_kind),
    .base_perm  (base_perm),
    .pid_hit    (pid_hit),
    .ent_dirty  (ent_dirty),
    .ent_brk    (ent_brk),
    .ent_trap   (ent_trap),
    .perm       (perm),
    .fault_code (fault_code)
  );

  assign fault_vld = (fault_code != 4'd0);
endmodule

// File: rtl/page_rights_check_sva.sv
module page_rights_check_sva #(
  parameter int PL_W = 2
) (
  input logic [PL_W-1:0] priv_lvl,
  input logic [1:0]      acc_kind,
  input logic [PL_W-1:0] ent_rd_pl,
  input logic [PL_W-1:0] ent_wr_pl,
  input logic            ent_dirty,
  input logic            ent_brk,
  input logic            ent_trap,
  input logic [2:0]      perm,
  input logic            fault_vld,
  input logic [3:0]      fault_code
);
  logic known;
  assign known = !$isunknown({priv_lvl, acc_kind, ent_rd_pl, ent_wr_pl,
                              ent_dirty, ent_brk, ent_trap, perm, fault_vld, fault_code});

  always_comb begin
    if (known) begin
      AST_READ_BOUND: assert (!perm[0] || priv_lvl <= ent_rd_pl) else $error("read bound"); // R1
      AST_WRITE_BOUND: assert (!perm[1] || priv_lvl <= ent_wr_pl) else $error("write bound"); // R1
      AST_EXEC_BOUND: assert (!perm[2] || (ent_wr_pl <= priv_lvl && priv_lvl <= ent_rd_pl)) else $error("exec bound"); // R1
      AST_PROBE_NO_FAULT: assert (acc_kind != 2'd0 || !fault_vld) else $error("probe fault"); // R5
      AST_INSN_ON_EXEC: assert (fault_code != 4'd2 || acc_kind == 2'd3) else $error("insn fault kind"); // R6
      AST_WRITE_CLEAN: assert (!(perm[1] && acc_kind != 2'd0 && !fault_vld) || (ent_dirty && !ent_brk && !ent_trap)) else $error("write kept"); // R7
      AST_DB_ON_WRITE: assert (!(fault_code == 4'd4 || fault_code == 4'd5) || acc_kind == 2'd2) else $error("dirty/break kind"); // R8
      AST_TRAP_NARROW: assert (!(ent_trap && acc_kind != 2'd0 && !fault_vld) || perm[1:0] == 2'b00) else $error("trap narrow"); // R9
      AST_VLD_CODE: assert (fault_vld == (fault_code != 4'd0)) else $error("vld mismatch"); // R11
    end
  end
endmodule

bind page_rights_check page_rights_check_sva #(.PL_W(PL_W)) u_sva (
  .priv_lvl   (priv_lvl),
  .acc_kind   (acc_kind),
  .ent_rd_pl  (ent_rd_pl),
  .ent_wr_pl  (ent_wr_pl),
  .ent_dirty  (ent_dirty),
  .ent_brk    (ent_brk),
  .ent_trap   (ent_trap),
  .perm       (perm),
  .fault_vld  (fault_vld),
  .fault_code (fault_code)
);

// File: tb/tb_page_rights_check.sv
`timescale 1ns/1ps
module tb_page_rights_check;
  localparam int PL_W    = 2;
  localparam int ID_W    = 8;
  localparam int NUM_PID = 4;
  localparam int PID_W   = ID_W + 1;
  localparam int NVEC    = 22;

  logic clk, rst_n;
  logic [PL_W-1:0]          priv_lvl;
  logic [1:0]               acc_kind;
  logic                     pid_chk_en;
  logic [NUM_PID*PID_W-1:0] pid_regs;
  logic [2:0]               ent_type;
  logic [PL_W-1:0]          ent_rd_pl, ent_wr_pl;
  logic [ID_W-1:0]          ent_id;
  logic                     ent_dirty, ent_brk, ent_trap;
  logic [2:0]               perm;
  logic                     fault_vld;
  logic [3:0]               fault_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  page_rights_check #(.PL_W(PL_W), .ID_W(ID_W), .NUM_PID(NUM_PID)) dut (
    .priv_lvl(priv_lvl), .acc_kind(acc_kind), .pid_chk_en(pid_chk_en),
    .pid_regs(pid_regs), .ent_type(ent_type), .ent_rd_pl(ent_rd_pl),
    .ent_wr_pl(ent_wr_pl), .ent_id(ent_id), .ent_dirty(ent_dirty),
    .ent_brk(ent_brk), .ent_trap(ent_trap), .perm(perm),
    .fault_vld(fault_vld), .fault_code(fault_code)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // kind, priv, type, rd_pl, wr_pl, dirty, brk, trap, exp_perm, exp_code
  localparam logic [20:0] VEC [NVEC] = '{
    {2'd1,2'd0,3'd0,2'd3,2'd3,1'b1,1'b0,1'b0,3'b001,4'd0},
    {2'd2,2'd0,3'd0,2'd3,2'd3,1'b1,1'b0,1'b0,3'b001,4'd3},
    {2'd2,2'd0,3'd1,2'd3,2'd3,1'b1,1'b0,1'b0,3'b011,4'd0},
    {2'd3,2'd0,3'd2,2'd3,2'd0,1'b1,1'b0,1'b0,3'b101,4'd0},
    {2'd3,2'd2,3'd2,2'd3,2'd0,1'b1,1'b0,1'b0,3'b101,4'd0},
    {2'd3,2'd3,3'd2,2'd2,2'd0,1'b1,1'b0,1'b0,3'b000,4'd2},
    {2'd3,2'd0,3'd2,2'd3,2'd1,1'b1,1'b0,1'b0,3'b001,4'd2},
    {2'd1,2'd2,3'd3,2'd2,2'd1,1'b1,1'b0,1'b0,3'b101,4'd0},
    {2'd2,2'd2,3'd3,2'd2,2'd1,1'b1,1'b0,1'b0,3'b101,4'd3},
    {2'd1,2'd1,3'd4,2'd3,2'd0,1'b1,1'b0,1'b0,3'b100,4'd3},
    {2'd3,2'd1,3'd7,2'd3,2'd0,1'b1,1'b0,1'b0,3'b100,4'd0},
    {2'd0,2'd3,3'd1,2'd0,2'd0,1'b1,1'b0,1'b0,3'b000,4'd0},
    {2'd0,2'd0,3'd3,2'd3,2'd0,1'b0,1'b1,1'b1,3'b111,4'd0},
    {2'd2,2'd0,3'd1,2'd3,2'd3,1'b0,1'b0,1'b0,3'b001,4'd4},
    {2'd1,2'd0,3'd1,2'd3,2'd3,1'b0,1'b0,1'b0,3'b001,4'd0},
    {2'd2,2'd0,3'd1,2'd3,2'd3,1'b1,1'b1,1'b0,3'b001,4'd5},
    {2'd2,2'd0,3'd1,2'd3,2'd3,1'b0,1'b1,1'b0,3'b001,4'd5},
    {2'd2,2'd0,3'd1,2'd3,2'd3,1'b1,1'b0,1'b1,3'b000,4'd6},
    {2'd2,2'd0,3'd1,2'd3,2'd3,1'b0,1'b1,1'b1,3'b000,4'd6},
    {2'd1,2'd0,3'd3,2'd3,2'd0,1'b1,1'b0,1'b1,3'b100,4'd6},
    {2'd3,2'd0,3'd3,2'd3,2'd0,1'b1,1'b0,1'b1,3'b100,4'd0},
    {2'd3,2'd0,3'd3,2'd3,2'd0,1'b0,1'b1,1'b0,3'b101,4'd0}
  };
  // requirement exercised by each vector (R1 R2 R5 R6 R7 R8 R9 R10)
  localparam int VREQ [NVEC] = '{2,6,2,2,1,6,1,1,6,2,2,5,5,7,7,8,10,9,10,9,9,8};

  task automatic check(input string tag, input logic [2:0] ep, input logic [3:0] ec);
    n_chk++;
    if (perm !== ep || fault_code !== ec || fault_vld !== (ec != 4'd0)) begin
      n_fail++;
      $display("FAIL %s: perm=%b code=%0d vld=%b expected perm=%b code=%0d vld=%b",
               tag, perm, fault_code, fault_vld, ep, ec, (ec != 4'd0));
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic [1:0] p, input logic [2:0] t,
                       input logic [1:0] rp, input logic [1:0] wp,
                       input logic d, input logic b, input logic tr);
    @(negedge clk);
    acc_kind = k; priv_lvl = p; ent_type = t; ent_rd_pl = rp; ent_wr_pl = wp;
    ent_dirty = d; ent_brk = b; ent_trap = tr;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0;
    priv_lvl = '0; acc_kind = '0; pid_chk_en = 0; pid_regs = '0; ent_type = '0;
    ent_rd_pl = '0; ent_wr_pl = '0; ent_id = '0; ent_dirty = 0; ent_brk = 0; ent_trap = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // idle inputs: probe of a type-0 page at level 0 with bounds 0 -> read only (R2 R5)
    check("R5 idle after reset", 3'b001, 4'd0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][20:19], VEC[i][18:17], VEC[i][16:14], VEC[i][13:12],
            VEC[i][11:10], VEC[i][9], VEC[i][8], VEC[i][7]);
      check($sformatf("R%0d vector %0d (R11 vld)", VREQ[i], i), VEC[i][6:4], VEC[i][3:0]);
    end

    // protection-identifier cases: id 0x25 -> key 9'h04B, placed in slot 3
    ent_id = 8'h25; pid_chk_en = 1;
    pid_regs = '0;
    pid_regs[3*PID_W +: PID_W] = 9'h04B;
    drive(2'd2, 2'd0, 3'd1, 2'd3, 2'd3, 1'b1, 1'b0, 1'b0);
    check("R3 pid match write", 3'b001, 4'd1);
    drive(2'd1, 2'd0, 3'd1, 2'd3, 2'd3, 1'b1, 1'b0, 1'b0);
    check("R3 pid match read", 3'b001, 4'd0);
    drive(2'd2, 2'd0, 3'd1, 2'd3, 2'd3, 1'b0, 1'b1, 1'b1);
    check("R3 pid fault precedes dirty/break/trap", 3'b001, 4'd1);
    drive(2'd0, 2'd0, 3'd3, 2'd3, 2'd0, 1'b1, 1'b0, 1'b0);
    check("R3 pid match probe narrows", 3'b101, 4'd0);
    pid_regs[3*PID_W +: PID_W] = 9'h04A;
    drive(2'd2, 2'd0, 3'd1, 2'd3, 2'd3, 1'b1, 1'b0, 1'b0);
    check("R3 near miss bit0", 3'b011, 4'd0);
    pid_regs[0 +: PID_W] = 9'h04B;
    pid_chk_en = 0;
    drive(2'd2, 2'd0, 3'd1, 2'd3, 2'd3, 1'b1, 1'b0, 1'b0);
    check("R4 checking disabled", 3'b011, 4'd0);
    pid_chk_en = 1; ent_id = '0;
    pid_regs[1*PID_W +: PID_W] = 9'h001;
    drive(2'd2, 2'd0, 3'd1, 2'd3, 2'd3, 1'b1, 1'b0, 1'b0);
    check("R4 public id zero", 3'b011, 4'd0);

    finish_run();
  end
endmodule